// File: doc/BRIEF.md
# Correntropy Window Datapath with Top-Two Peak Monitor

This block scores how closely an image window matches a reference kernel, one window per clock. For every element it takes the absolute difference between the window pixel and the kernel pixel. It turns that difference into a similarity weight through a small lookup table that approximates a Gaussian falloff. It then adds all the weights in a pipelined adder tree. A new window can enter on every cycle, and one correntropy score leaves the tree on every cycle after a fixed latency.

A monitor at the tail of the pipeline watches the score stream. It keeps the two best scores of the current frame, each with the row and column that the caller attached to its window. A frame-start flag travels down the pipeline beside the window it marks. When that flag reaches the monitor, the monitor empties itself before it considers the marked window. The weight table starts with a fixed descending ramp at reset. A simple write port can overwrite any entry.

Top module: `corr_peak_dp`

## Requirements
- R1: Each element's difference is |window − kernel| on unsigned 16-bit pixels, so swapping the window and kernel values gives the same score.
- R2: Each element's weight is table entry number (difference >> 6), and the score is the sum of the weights of all 9 elements.
- R3: A difference of 4096 or more (shifted index above 63) uses table entry 63.
- R4: After reset, table entry i holds (63 − i) × 1024, so entry 0 is 64512 and entry 63 is 0.
- R5: When `tbl_we` is high on a clock edge, entry `tbl_addr` takes `tbl_data`, and windows sampled on later edges use the new value.
- R6: `out_valid` and `out_sum` for a window appear exactly 6 clock edges after the edge that samples that window with `in_valid` high. Back-to-back windows give back-to-back scores.
- R7: A score strictly greater than the best value becomes the best, and the old best becomes the second. Otherwise a score strictly greater than the second replaces the second. An equal score changes nothing. The maxima outputs update one edge after `out_valid`.
- R8: Each stored maximum carries the `in_row` and `in_col` given with the window that produced it.
- R9: `in_frame_start` sampled with a window, valid or not, clears both maxima (value, row and column to 0) at the moment that window reaches the monitor. If that window is valid, its score is then ranked against the emptied maxima.
- R10: After reset, `out_valid` is 0 and both maxima read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Window and kernel are valid this cycle |
| in_frame_start | input | 1 | Marks the first window of a frame; clears the maxima |
| in_row | input | 12 | Row position attached to this window |
| in_col | input | 12 | Column position attached to this window |
| in_win | input | 144 | Nine 16-bit window pixels, element e at bits [16e+15:16e] |
| in_krn | input | 144 | Nine 16-bit kernel pixels, same layout |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 6 | Table entry to write |
| tbl_data | input | 16 | Value to write |
| out_valid | output | 1 | A score is present on out_sum |
| out_sum | output | 20 | Correntropy score |
| max1_val | output | 20 | Best score of the frame |
| max1_row | output | 12 | Row of the best score |
| max1_col | output | 12 | Column of the best score |
| max2_val | output | 20 | Second-best score of the frame |
| max2_row | output | 12 | Row of the second-best score |
| max2_col | output | 12 | Column of the second-best score |

## Verification
The frame clear and the ranking of a new score can land on the monitor in the same cycle. This happens whenever the frame-start flag rides on a valid window. The correct result is that the old maxima vanish and that window's score becomes the best, even when it is smaller than both previous maxima. The bench provokes this by opening a second frame with a deliberately weak window after two strong ones. It judges the outcome from a reference ranking model that clears before it ranks. A flag-only clear with no valid window is also checked, and so are equal scores arriving against both stored maxima.

// File: rtl/corr_pkg.sv
package corr_pkg;

    localparam int POS_W = 12;

    // sideband that travels with each window down the pipeline
    typedef struct packed {
        logic             vld;
        logic             fs;
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
    } tag_t;

    function automatic int score_width(input int val_w, input int nelem);
        return val_w + $clog2(nelem);
    endfunction

endpackage

// File: rtl/corr_lut.sv
module corr_lut #(
    parameter int NELEM = 9,
    parameter int PIX_W = 16,
    parameter int VAL_W = 16,
    parameter int IDX_W = 6,
    parameter int SHIFT = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_addr,
    input  logic [VAL_W-1:0]                  wr_data,
    input  logic [NELEM-1:0][PIX_W-1:0]       diff_i,
    output logic [NELEM-1:0][VAL_W-1:0]       val_o
);

    localparam int LUT_N   = 1 << IDX_W;
    localparam int STEP_SH = VAL_W - IDX_W;

    typedef struct packed {
        logic [LUT_N-1:0][VAL_W-1:0] tbl;
        logic [NELEM-1:0][VAL_W-1:0] val;
    } lut_st_t;

    lut_st_t lut_d, lut_q;

    function automatic lut_st_t reset_state();
        lut_st_t s;
        s = '0;
        for (int i = 0; i < LUT_N; i++) begin
            s.tbl[i] = VAL_W'(LUT_N - 1 - i) << STEP_SH;
        end
        return s;
    endfunction

    function automatic logic [IDX_W-1:0] to_index(input logic [PIX_W-1:0] d);
        logic [PIX_W-1:0] q;
        q = d >> SHIFT;
        if (q > PIX_W'(LUT_N - 1)) begin
            return IDX_W'(LUT_N - 1);
        end
        return q[IDX_W-1:0];
    endfunction

    always_comb begin
        lut_d = lut_q;
        if (wr_en) begin
            lut_d.tbl[wr_addr] = wr_data;
        end
        for (int e = 0; e < NELEM; e++) begin
            lut_d.val[e] = lut_q.tbl[to_index(diff_i[e])];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lut_q <= reset_state();
        end else begin
            lut_q <= lut_d;
        end
    end

    assign val_o = lut_q.val;

    // R5
    tbl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (lut_q.tbl[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/corr_tree.sv
module corr_tree #(
    parameter int NELEM = 9,
    parameter int VAL_W = 16,
    parameter int SUM_W = 20
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NELEM-1:0][VAL_W-1:0] leaf_i,
    output logic [SUM_W-1:0]            sum_o
);

    localparam int LEVELS = $clog2(NELEM);
    localparam int PAD    = 1 << LEVELS;
    localparam int NODES  = PAD - 1;

    logic [NODES-1:0][SUM_W-1:0] node_d, node_q;
    logic [PAD-1:0][SUM_W-1:0]   leaf_pad;
    logic [2*PAD-2:1][SUM_W-1:0] heap_all;

    always_comb begin
        leaf_pad = '0;
        for (int j = 0; j < NELEM; j++) begin
            leaf_pad[j] = SUM_W'(leaf_i[j]);
        end
    end

    // heap layout: internal nodes 1..PAD-2, leaves PAD-1..2*PAD-2
    for (genvar gi = 1; gi <= 2*PAD-2; gi++) begin : g_heap
        if (gi < PAD - 1) begin : g_node
            assign heap_all[gi] = node_q[gi];
        end else begin : g_leaf
            assign heap_all[gi] = leaf_pad[gi-(PAD-1)];
        end
    end

    always_comb begin
        for (int k = 0; k < NODES; k++) begin
            node_d[k] = heap_all[2*k+1] + heap_all[2*k+2];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            node_q <= '0;
        end else begin
            node_q <= node_d;
        end
    end

    assign sum_o = node_q[0];

endmodule

// File: rtl/corr_peak.sv
module corr_peak
    import corr_pkg::*;
#(
    parameter int SUM_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tag_t             tag_i,
    input  logic [SUM_W-1:0] val_i,
    output logic [SUM_W-1:0] max1_val_o,
    output logic [POS_W-1:0] max1_row_o,
    output logic [POS_W-1:0] max1_col_o,
    output logic [SUM_W-1:0] max2_val_o,
    output logic [POS_W-1:0] max2_row_o,
    output logic [POS_W-1:0] max2_col_o
);

    typedef struct packed {
        logic [SUM_W-1:0] val;
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
    } peak_ent_t;

    typedef struct packed {
        peak_ent_t m1;
        peak_ent_t m2;
    } peak_st_t;

    peak_st_t  peak_d, peak_q;
    peak_st_t  base;
    peak_ent_t cand;

    always_comb begin
        base = peak_q;
        if (tag_i.fs) begin
            base = '0;
        end
        cand   = '{val: val_i, row: tag_i.row, col: tag_i.col};
        peak_d = base;
        if (tag_i.vld) begin
            if (val_i > base.m1.val) begin
                peak_d.m2 = base.m1;
                peak_d.m1 = cand;
            end else if (val_i > base.m2.val) begin
                peak_d.m2 = cand;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            peak_q <= '0;
        end else begin
            peak_q <= peak_d;
        end
    end

    assign max1_val_o = peak_q.m1.val;
    assign max1_row_o = peak_q.m1.row;
    assign max1_col_o = peak_q.m1.col;
    assign max2_val_o = peak_q.m2.val;
    assign max2_row_o = peak_q.m2.row;
    assign max2_col_o = peak_q.m2.col;

    // R7
    peak_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        max1_val_o >= max2_val_o);

    // R7
    peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tag_i.fs |=> (max1_val_o >= $past(max1_val_o)) && (max2_val_o >= $past(max2_val_o)));

    // R7
    peak_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i.vld && !tag_i.fs && val_i == max1_val_o)
        |=> ($stable(max1_row_o) && $stable(max1_col_o)));

    // R9
    peak_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i.fs && !tag_i.vld) |=> (max1_val_o == '0 && max2_val_o == '0));

endmodule

// File: rtl/corr_peak_dp.sv
module corr_peak_dp
    import corr_pkg::*;
#(
    parameter int NELEM = 9,
    parameter int PIX_W = 16,
    parameter int VAL_W = 16,
    parameter int IDX_W = 6,
    parameter int SHIFT = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  logic                               in_frame_start,
    input  logic [POS_W-1:0]                   in_row,
    input  logic [POS_W-1:0]                   in_col,
    input  logic [NELEM*PIX_W-1:0]             in_win,
    input  logic [NELEM*PIX_W-1:0]             in_krn,
    input  logic                               tbl_we,
    input  logic [IDX_W-1:0]                   tbl_addr,
    input  logic [VAL_W-1:0]                   tbl_data,
    output logic                               out_valid,
    output logic [VAL_W+$clog2(NELEM)-1:0]     out_sum,
    output logic [VAL_W+$clog2(NELEM)-1:0]     max1_val,
    output logic [POS_W-1:0]                   max1_row,
    output logic [POS_W-1:0]                   max1_col,
    output logic [VAL_W+$clog2(NELEM)-1:0]     max2_val,
    output logic [POS_W-1:0]                   max2_row,
    output logic [POS_W-1:0]                   max2_col
);

    localparam int LEVELS = $clog2(NELEM);
    localparam int SUM_W  = score_width(VAL_W, NELEM);
    localparam int LAT    = LEVELS + 2;

    typedef struct packed {
        tag_t                         s1_tag;
        logic [NELEM-1:0][PIX_W-1:0]  diff;
        tag_t [LEVELS:0]              tagp;
    } dp_st_t;

    dp_st_t dp_d, dp_q;

    logic [NELEM-1:0][PIX_W-1:0] win_v, krn_v;
    logic [NELEM-1:0][VAL_W-1:0] weight;
    logic [SUM_W-1:0]            tree_sum;

    assign win_v = in_win;
    assign krn_v = in_krn;

    always_comb begin
        dp_d        = dp_q;
        dp_d.s1_tag = '{vld: in_valid, fs: in_frame_start, row: in_row, col: in_col};
        for (int e = 0; e < NELEM; e++) begin
            dp_d.diff[e] = (win_v[e] >= krn_v[e]) ? (win_v[e] - krn_v[e])
                                                   : (krn_v[e] - win_v[e]);
        end
        dp_d.tagp[0] = dp_q.s1_tag;
        for (int i = 1; i <= LEVELS; i++) begin
            dp_d.tagp[i] = dp_q.tagp[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    corr_lut #(
        .NELEM (NELEM),
        .PIX_W (PIX_W),
        .VAL_W (VAL_W),
        .IDX_W (IDX_W),
        .SHIFT (SHIFT)
    ) u_lut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_addr (tbl_addr),
        .wr_data (tbl_data),
        .diff_i  (dp_q.diff),
        .val_o   (weight)
    );

    corr_tree #(
        .NELEM (NELEM),
        .VAL_W (VAL_W),
        .SUM_W (SUM_W)
    ) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .leaf_i (weight),
        .sum_o  (tree_sum)
    );

    corr_peak #(
        .SUM_W (SUM_W)
    ) u_peak (
        .clk        (clk),
        .rst_n      (rst_n),
        .tag_i      (dp_q.tagp[LEVELS]),
        .val_i      (tree_sum),
        .max1_val_o (max1_val),
        .max1_row_o (max1_row),
        .max1_col_o (max1_col),
        .max2_val_o (max2_val),
        .max2_row_o (max2_row),
        .max2_col_o (max2_col)
    );

    assign out_valid = dp_q.tagp[LEVELS].vld;
    assign out_sum   = tree_sum;

    // R6
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, LAT));

    // R9
    fs_travel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dp_q.tagp[LEVELS].fs |-> $past(in_frame_start, LAT));

endmodule

// File: tb/sim_corr_peak_dp.sv
`timescale 1ns/1ps
module sim_corr_peak_dp;
    import corr_pkg::*;

    localparam int NE  = 9;
    localparam int PW  = 16;
    localparam int VW  = 16;
    localparam int IW  = 6;
    localparam int SH  = 6;
    localparam int SW  = VW + $clog2(NE);
    localparam int LAT = $clog2(NE) + 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_frame_start = 1'b0;
    logic [POS_W-1:0]  in_row = '0;
    logic [POS_W-1:0]  in_col = '0;
    logic [NE*PW-1:0]  in_win = '0;
    logic [NE*PW-1:0]  in_krn = '0;
    logic              tbl_we = 1'b0;
    logic [IW-1:0]     tbl_addr = '0;
    logic [VW-1:0]     tbl_data = '0;
    logic              out_valid;
    logic [SW-1:0]     out_sum, max1_val, max2_val;
    logic [POS_W-1:0]  max1_row, max1_col, max2_row, max2_col;

    corr_peak_dp u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_frame_start(in_frame_start),
        .in_row(in_row), .in_col(in_col), .in_win(in_win), .in_krn(in_krn),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
        .out_valid(out_valid), .out_sum(out_sum),
        .max1_val(max1_val), .max1_row(max1_row), .max1_col(max1_col),
        .max2_val(max2_val), .max2_row(max2_row), .max2_col(max2_col)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int pe = 0;
    int mtab[64];
    int pa[NE];
    int ka[NE];

    int    q_sum[$];
    int    q_row[$];
    int    q_col[$];
    int    q_cyc[$];
    bit    q_fs[$];
    string q_tag[$];

    int    m1v = 0, m1r = 0, m1c = 0, m2v = 0, m2r = 0, m2c = 0;
    bit    cmp_next = 1'b0;
    string cmp_tag = "";

    always @(posedge clk) pe <= pe + 1;

    task automatic chk(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cmp_peaks(input string tag);
        chk(tag, "max1_val", max1_val, m1v);
        chk(tag, "max1_row", max1_row, m1r);
        chk(tag, "max1_col", max1_col, m1c);
        chk(tag, "max2_val", max2_val, m2v);
        chk(tag, "max2_row", max2_row, m2r);
        chk(tag, "max2_col", max2_col, m2c);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmp_next) begin
                cmp_peaks(cmp_tag);
                cmp_next = 1'b0;
            end
            if (out_valid) begin
                if (q_sum.size() == 0) begin
                    chk("R6", "unexpected out_valid", 1, 0);
                end else begin
                    int    es, er, ec, ecyc;
                    bit    efs;
                    string et;
                    es = q_sum.pop_front(); er = q_row.pop_front(); ec = q_col.pop_front();
                    ecyc = q_cyc.pop_front(); efs = q_fs.pop_front(); et = q_tag.pop_front();
                    chk(et, "out_sum", out_sum, es);
                    chk("R6", "latency", pe - ecyc, LAT);
                    if (efs) begin
                        m1v = 0; m1r = 0; m1c = 0; m2v = 0; m2r = 0; m2c = 0;
                    end
                    if (es > m1v) begin
                        m2v = m1v; m2r = m1r; m2c = m1c;
                        m1v = es;  m1r = er;  m1c = ec;
                    end else if (es > m2v) begin
                        m2v = es;  m2r = er;  m2c = ec;
                    end
                    cmp_next = 1'b1;
                    cmp_tag  = efs ? "R9" : "R7/R8";
                end
            end
        end
    end

    task automatic send(input int row, input int col, input bit fs, input string tag);
        int s;
        s = 0;
        for (int e = 0; e < NE; e++) begin
            int d, ix;
            d  = (pa[e] > ka[e]) ? pa[e] - ka[e] : ka[e] - pa[e];
            ix = d >> SH;
            if (ix > 63) ix = 63;
            s += mtab[ix];
            in_win[e*PW +: PW] = PW'(pa[e]);
            in_krn[e*PW +: PW] = PW'(ka[e]);
        end
        in_valid       = 1'b1;
        in_frame_start = fs;
        in_row         = POS_W'(row);
        in_col         = POS_W'(col);
        q_sum.push_back(s); q_row.push_back(row); q_col.push_back(col);
        q_cyc.push_back(pe); q_fs.push_back(fs); q_tag.push_back(tag);
        @(negedge clk);
        in_valid       = 1'b0;
        in_frame_start = 1'b0;
    endtask

    task automatic uniform(input int d);
        for (int e = 0; e < NE; e++) begin
            pa[e] = d;
            ka[e] = 0;
        end
    endtask

    task automatic write_tbl(input int a, input int v);
        tbl_we   = 1'b1;
        tbl_addr = IW'(a);
        tbl_data = VW'(v);
        @(negedge clk);
        tbl_we = 1'b0;
        mtab[a] = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        chk("WDOG", "watchdog expired", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        // R4: independent model of the reset ramp
        for (int i = 0; i < 64; i++) mtab[i] = (63 - i) * 1024;

        idle(4);
        // R10
        chk("R10", "out_valid in reset", out_valid, 0);
        rst_n = 1'b1;
        idle(3);
        chk("R10", "out_valid after reset", out_valid, 0);
        chk("R10", "max1_val after reset", max1_val, 0);
        chk("R10", "max2_val after reset", max2_val, 0);
        chk("R10", "max1_row after reset", max1_row, 0);

        // R4: each element selects a different reset entry
        for (int e = 0; e < NE; e++) begin
            ka[e] = 1000;
            pa[e] = 1000 + e * 7 * 64;
        end
        send(0, 0, 1'b0, "R4");
        idle(LAT + 2);

        // R1: window below and above the kernel
        for (int e = 0; e < NE; e++) begin
            pa[e] = 200;
            ka[e] = 200 + e * 300;
        end
        send(0, 1, 1'b0, "R1");
        for (int e = 0; e < NE; e++) begin
            pa[e] = 200 + e * 300;
            ka[e] = 200;
        end
        send(0, 2, 1'b0, "R1");

        // R2: differences on both sides of index boundaries
        pa[0] = 63;  pa[1] = 64;  pa[2] = 127; pa[3] = 128; pa[4] = 191;
        pa[5] = 192; pa[6] = 1;   pa[7] = 4000; pa[8] = 3000;
        for (int e = 0; e < NE; e++) ka[e] = 0;
        send(0, 3, 1'b0, "R2");
        idle(LAT + 2);

        // R5: table writes take effect
        write_tbl(0, 12345);
        write_tbl(62, 900);
        write_tbl(63, 777);
        uniform(0);
        send(0, 4, 1'b0, "R5");

        // R3: saturation at the table end
        pa[0] = 4095;  pa[1] = 4096; pa[2] = 5000; pa[3] = 65535; pa[4] = 4031;
        pa[5] = 4032;  pa[6] = 30000; pa[7] = 8191; pa[8] = 0;
        for (int e = 0; e < NE; e++) ka[e] = 0;
        send(0, 5, 1'b0, "R3");
        for (int e = 0; e < NE; e++) begin
            ka[e] = 65535;
            pa[e] = 0;
        end
        send(0, 6, 1'b0, "R3");
        idle(LAT + 2);

        // R7/R8/R9: frame opened by a valid window, ranking and ties
        uniform(64 * 10); send(10, 1, 1'b1, "R9");
        uniform(64 * 20); send(10, 2, 1'b0, "R7/R8");
        uniform(64 * 5);  send(10, 3, 1'b0, "R7/R8");
        uniform(64 * 5);  send(10, 4, 1'b0, "R7 tie max1");
        uniform(64 * 10); send(10, 5, 1'b0, "R7 tie max2");
        uniform(64 * 8);  send(10, 6, 1'b0, "R7/R8");
        // R9: clear and ranking in the same cycle with a weak window
        uniform(64 * 40); send(11, 0, 1'b1, "R9");
        uniform(64 * 30); send(11, 1, 1'b0, "R7/R8");
        idle(LAT + 3);

        // R9: flag with no valid window
        in_frame_start = 1'b1;
        @(negedge clk);
        in_frame_start = 1'b0;
        idle(LAT + 2);
        m1v = 0; m1r = 0; m1c = 0; m2v = 0; m2r = 0; m2c = 0;
        cmp_peaks("R9");

        // R6: random back-to-back stream
        for (int n = 0; n < 40; n++) begin
            for (int e = 0; e < NE; e++) begin
                pa[e] = $urandom_range(0, 9000);
                ka[e] = $urandom_range(0, 9000);
            end
            send(20 + n / 8, n % 8, (n == 16), "R6");
        end
        idle(LAT + 4);
        chk("R6", "queue drained", q_sum.size(), 0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule